// File: doc/BRIEF.md
# I2C Target with Pointer-Addressed Control Registers

This block is a two-wire serial bus target that answers at 7-bit address 0x06. Behind a command pointer it exposes two read/write control bytes at 0x20 and 0x21 and one read-only status byte at 0x22. The control bytes leave the block as parallel outputs. The status byte is a per-cycle capture of a status input.

The bus lines are oversampled on the system clock. Each line passes through a two-flop synchronizer and then a persistence filter. START, repeated START and STOP are found on the filtered lines. In a write transaction the first data byte always loads the pointer. Every later byte goes to the register the pointer names, and the pointer then steps forward by one. A read begins at the current pointer. That pointer survives STOP, so a read without a fresh pointer-set returns the same register again. The block pulls SDA low through an open-drain enable and never stretches the clock.

Top module: `ptr_reg_i2c_target`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal 0x06, with the last bit as direction (0 = write, 1 = read). Any other address gets no acknowledge, and the bytes that follow it change nothing.
- R2: After reset, ctrl0_o = 0x90 and ctrl1_o = 0x2C. A read of 0x20, 0x21, 0x22 in sequence returns 0x90, 0x2C and then the status input value.
- R3: In a write transaction the first byte after the address sets the pointer. Each further byte is stored at the pointer, and the pointer then increments by one, so consecutive bytes fill consecutive registers.
- R4: The pointer is kept across STOP. A master NACK does not advance it, so a read with no pointer-set returns the register read last.
- R5: Read data goes out MSB first, starting on the clock after the address acknowledge. A master ACK makes the block increment the pointer and send the next register.
- R6: A pointer-set followed by a repeated START and a read address returns data from the new pointer.
- R7: A write to 0x22 or to any unmapped pointer is acknowledged and discarded. A read of 0x22 returns the status input. A read of an unmapped pointer returns 0x00.
- R8: A pulse on SCL shorter than FILT_CYC system clocks is ignored, and the byte being transferred is received unchanged.
- R9: A STOP or START in the middle of a byte abandons that byte, so no register is written. A START returns the block to the address phase.
- R10: The block drives SDA low for the acknowledge clock after every byte it receives in an addressed write. It changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| stat_i | input | 8 | Status value captured into the read-only register |
| ctrl0_o | output | 8 | Control byte stored at pointer 0x20 |
| ctrl1_o | output | 8 | Control byte stored at pointer 0x21 |

## Verification
Random rounds write two bytes from a random starting pointer in 0x1F..0x23, so some rounds straddle the sparse map edges. They then read two bytes back from another random pointer through a repeated START. This tells mapped registers apart from unmapped ones and shows the read-only register ignoring writes. Every second round injects a short SCL pulse inside a data byte, which separates a working filter from one that counts a false bit. Directed sequences cover a foreign address, reads that rely on the kept pointer, and bytes cut short by STOP or by a repeated START. These tell an abandoned byte apart from one that was committed.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
    localparam int DW = 8;
    localparam logic [6:0] DEV_ADDR = 7'h06;
    localparam logic [DW-1:0] REG_CTRL0 = 8'h20;
    localparam logic [DW-1:0] REG_CTRL1 = 8'h21;
    localparam logic [DW-1:0] REG_STAT  = 8'h22;
    localparam logic [DW-1:0] RST_CTRL0 = 8'h90;
    localparam logic [DW-1:0] RST_CTRL1 = 8'h2C;
    localparam logic [DW-1:0] RST_STAT  = 8'h0E;
    localparam int BCW = $clog2(DW + 1);

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_AACK, PH_WBYTE, PH_WACK, PH_RBYTE, PH_RACK
    } phase_e;

    typedef struct packed {
        phase_e          phase;
        logic [DW-1:0]   shift;
        logic [BCW-1:0]  bitcnt;
        logic [DW-1:0]   ptr;
        logic            ptr_pend;
        logic            rw;
        logic            mack;
        logic            drive;
        logic            scl_p;
        logic            sda_p;
        logic            wr_en;
        logic [DW-1:0]   wr_addr;
        logic [DW-1:0]   wr_data;
    } eng_t;

    typedef struct packed {
        logic [DW-1:0] ctrl0;
        logic [DW-1:0] ctrl1;
        logic [DW-1:0] stat;
    } regs_t;
endpackage

// File: rtl/i2ct_glitch_filter.sv
`timescale 1ns/1ps
module i2ct_glitch_filter #(
    parameter int LINES    = 2,
    parameter int FILT_CYC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] clean_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        typedef struct packed {
            logic [1:0]    sync;
            logic          clean;
            logic [CW-1:0] cnt;
        } flt_t;

        flt_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.sync = {st_q.sync[0], raw_i[g]};
            if (st_q.sync[1] == st_q.clean) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CW'(FILT_CYC - 1)) begin
                st_d.clean = st_q.sync[1];
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '{sync: 2'b11, clean: 1'b1, cnt: '0};
            end else begin
                st_q <= st_d;
            end
        end

        assign clean_o[g] = st_q.clean;
    end
endmodule

// File: rtl/i2ct_regfile.sv
`timescale 1ns/1ps
module i2ct_regfile
    import i2ct_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_addr,
    input  logic [DW-1:0] stat_i,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ctrl0_o,
    output logic [DW-1:0] ctrl1_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.stat = stat_i;
        if (wr_en) begin
            case (wr_addr)
                REG_CTRL0: r_d.ctrl0 = wr_data;
                REG_CTRL1: r_d.ctrl1 = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ctrl0: RST_CTRL0, ctrl1: RST_CTRL1, stat: RST_STAT};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (rd_addr)
            REG_CTRL0: rd_data = r_q.ctrl0;
            REG_CTRL1: rd_data = r_q.ctrl1;
            REG_STAT:  rd_data = r_q.stat;
            default:   rd_data = '0;
        endcase
    end

    assign ctrl0_o = r_q.ctrl0;
    assign ctrl1_o = r_q.ctrl1;
endmodule

// File: rtl/i2ct_engine.sv
`timescale 1ns/1ps
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe
);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW);

    eng_t e_d, e_q;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    always_comb begin
        scl_rise = scl_f & ~e_q.scl_p;
        scl_fall = ~scl_f & e_q.scl_p;
        start_ev = scl_f & e_q.scl_p & e_q.sda_p & ~sda_f;
        stop_ev  = scl_f & e_q.scl_p & ~e_q.sda_p & sda_f;

        e_d       = e_q;
        e_d.wr_en = 1'b0;
        e_d.scl_p = scl_f;
        e_d.sda_p = sda_f;

        if (stop_ev) begin
            e_d.phase = PH_IDLE;
            e_d.drive = 1'b0;
        end else if (start_ev) begin
            e_d.phase  = PH_ADDR;
            e_d.bitcnt = '0;
            e_d.drive  = 1'b0;
        end else begin
            case (e_q.phase)
                PH_ADDR: begin
                    if (scl_rise) begin
                        e_d.shift  = {e_q.shift[DW-2:0], sda_f};
                        e_d.bitcnt = e_q.bitcnt + 1'b1;
                    end else if (scl_fall && e_q.bitcnt == LAST_BIT) begin
                        if (e_q.shift[DW-1:1] == DEV_ADDR) begin
                            e_d.phase = PH_AACK;
                            e_d.drive = 1'b1;
                            e_d.rw    = e_q.shift[0];
                        end else begin
                            e_d.phase = PH_IDLE;
                        end
                    end
                end
                PH_AACK: begin
                    if (scl_fall) begin
                        e_d.bitcnt = '0;
                        if (e_q.rw) begin
                            e_d.phase = PH_RBYTE;
                            e_d.shift = rd_data;
                            e_d.drive = ~rd_data[DW-1];
                        end else begin
                            e_d.phase    = PH_WBYTE;
                            e_d.drive    = 1'b0;
                            e_d.ptr_pend = 1'b1;
                        end
                    end
                end
                PH_WBYTE: begin
                    if (scl_rise) begin
                        e_d.shift  = {e_q.shift[DW-2:0], sda_f};
                        e_d.bitcnt = e_q.bitcnt + 1'b1;
                    end else if (scl_fall && e_q.bitcnt == LAST_BIT) begin
                        e_d.phase = PH_WACK;
                        e_d.drive = 1'b1;
                        if (e_q.ptr_pend) begin
                            e_d.ptr      = e_q.shift;
                            e_d.ptr_pend = 1'b0;
                        end else begin
                            e_d.wr_en   = 1'b1;
                            e_d.wr_addr = e_q.ptr;
                            e_d.wr_data = e_q.shift;
                            e_d.ptr     = e_q.ptr + 1'b1;
                        end
                    end
                end
                PH_WACK: begin
                    if (scl_fall) begin
                        e_d.phase  = PH_WBYTE;
                        e_d.drive  = 1'b0;
                        e_d.bitcnt = '0;
                    end
                end
                PH_RBYTE: begin
                    if (scl_rise) begin
                        e_d.bitcnt = e_q.bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (e_q.bitcnt == LAST_BIT) begin
                            e_d.phase = PH_RACK;
                            e_d.drive = 1'b0;
                        end else begin
                            e_d.shift = {e_q.shift[DW-2:0], 1'b0};
                            e_d.drive = ~e_q.shift[DW-2];
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        e_d.mack = ~sda_f;
                        if (!sda_f) begin
                            e_d.ptr = e_q.ptr + 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (e_q.mack) begin
                            e_d.phase  = PH_RBYTE;
                            e_d.bitcnt = '0;
                            e_d.shift  = rd_data;
                            e_d.drive  = ~rd_data[DW-1];
                        end else begin
                            e_d.phase = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{phase: PH_IDLE, shift: '0, bitcnt: '0, ptr: '0,
                     ptr_pend: 1'b0, rw: 1'b0, mack: 1'b0, drive: 1'b0,
                     scl_p: 1'b1, sda_p: 1'b1, wr_en: 1'b0,
                     wr_addr: '0, wr_data: '0};
        end else begin
            e_q <= e_d;
        end
    end

    assign rd_addr = e_q.ptr;
    assign wr_en   = e_q.wr_en;
    assign wr_addr = e_q.wr_addr;
    assign wr_data = e_q.wr_data;
    assign sda_oe  = e_q.drive;
endmodule

// File: rtl/ptr_reg_i2c_target.sv
`timescale 1ns/1ps
module ptr_reg_i2c_target
    import i2ct_pkg::*;
#(
    parameter int FILT_CYC = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    input  logic [DW-1:0] stat_i,
    output logic [DW-1:0] ctrl0_o,
    output logic [DW-1:0] ctrl1_o
);
    logic [1:0]    lines_f;
    logic          scl_f, sda_f;
    logic [DW-1:0] rd_data, rd_addr, wr_addr, wr_data;
    logic          wr_en;

    i2ct_glitch_filter #(.LINES(2), .FILT_CYC(FILT_CYC)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({sda_i, scl_i}),
        .clean_o (lines_f)
    );

    assign scl_f = lines_f[0];
    assign sda_f = lines_f[1];

    i2ct_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe_o)
    );

    i2ct_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .stat_i  (stat_i),
        .rd_data (rd_data),
        .ctrl0_o (ctrl0_o),
        .ctrl1_o (ctrl1_o)
    );
endmodule

// File: rtl/ptr_reg_i2c_target_chk.sv
`timescale 1ns/1ps
module ptr_reg_i2c_target_chk
    import i2ct_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          scl_f,
    input logic          sda_f,
    input logic          sda_oe,
    input logic          wr_en,
    input logic [DW-1:0] wr_addr,
    input logic [DW-1:0] ctrl0,
    input logic [DW-1:0] ctrl1
);
    assert_ctrl0_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl0) |-> $past(wr_en && wr_addr == REG_CTRL0));

    assert_ctrl1_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl1) |-> $past(wr_en && wr_addr == REG_CTRL1));

    assert_other_write_discarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != REG_CTRL0 && wr_addr != REG_CTRL1)
        |=> ($stable(ctrl0) && $stable(ctrl1)));

    assert_drive_on_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $rose(sda_f)) |=> !sda_oe);
endmodule

bind ptr_reg_i2c_target ptr_reg_i2c_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .sda_oe  (sda_oe_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .ctrl0   (ctrl0_o),
    .ctrl1   (ctrl1_o)
);

// File: tb/tb_ptr_reg_i2c_target.sv
`timescale 1ns/1ps
module tb_ptr_reg_i2c_target;
    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] stat_i = 8'h0E;
    logic       sda_oe;
    logic [7:0] c0, c1;
    logic       sda_line;
    int         nchk = 0;
    int         nerr = 0;
    bit         done = 0;
    logic [7:0] m0 = 8'h90;
    logic [7:0] m1 = 8'h2C;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    ptr_reg_i2c_target dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .stat_i   (stat_i),
        .ctrl0_o  (c0),
        .ctrl1_o  (c1)
    );

    function automatic logic [7:0] exp_reg(input logic [7:0] a);
        case (a)
            8'h20:   return m0;
            8'h21:   return m1;
            8'h22:   return stat_i;
            default: return 8'h00;
        endcase
    endfunction

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(2*Q);
        sda_m = 1'b0; wt(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(2*Q);
        sda_m = 1'b1; wt(2*Q);
    endtask

    task automatic clk_bit(input logic b, input bit gl, output logic r);
        wt(Q); sda_m = b; wt(Q); scl_m = 1'b1;
        if (gl) begin
            wt(8); scl_m = 1'b0; wt(4); scl_m = 1'b1; wt(Q - 12);
        end else begin
            wt(Q);
        end
        r = sda_line;
        wt(Q); scl_m = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] d, input bit gl, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], gl && (i == 3), r);
        clk_bit(1'b1, 1'b0, r);
        ack = ~r;
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, r);
            d[i] = r;
        end
        clk_bit(~mack, 1'b0, r);
    endtask

    function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h20) m0 = d;
        else if (a == 8'h21) m1 = d;
    endfunction

    task automatic do_write(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1,
                            input int nd, input bit gl);
        logic ack;
        bus_start();
        wbyte(8'h0C, 1'b0, ack); chk("R1 addr ack", {7'd0, ack}, 8'd1);
        wbyte(p, 1'b0, ack);     chk("R10 ptr ack", {7'd0, ack}, 8'd1);
        wbyte(d0, gl, ack);      chk("R10 data ack", {7'd0, ack}, 8'd1);
        model_wr(p, d0);
        if (nd > 1) begin
            wbyte(d1, 1'b0, ack); chk("R10 data ack", {7'd0, ack}, 8'd1);
            model_wr(p + 8'd1, d1);
        end
        bus_stop();
        wt(40);
    endtask

    task automatic do_read(input bit setp, input logic [7:0] p, input int nr,
                           output logic [31:0] buf_o);
        logic ack;
        logic [7:0] d;
        buf_o = '0;
        if (setp) begin
            bus_start();
            wbyte(8'h0C, 1'b0, ack); chk("R6 addr ack", {7'd0, ack}, 8'd1);
            wbyte(p, 1'b0, ack);     chk("R6 ptr ack", {7'd0, ack}, 8'd1);
        end
        bus_start();
        wbyte(8'h0D, 1'b0, ack); chk("R1 read addr ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < nr; i++) begin
            rbyte(i != nr - 1, d);
            buf_o[8*i +: 8] = d;
        end
        bus_stop();
        wt(40);
    endtask

    initial begin
        wt(180000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] rb;
        logic        ack, r;
        logic [7:0]  p, q, d0, d1;
        void'($urandom(32'd1234));
        wt(10);
        rst_n = 1'b1;
        wt(10);

        // R2: reset values at the outputs and through a read burst
        chk("R2 ctrl0 reset", c0, 8'h90);
        chk("R2 ctrl1 reset", c1, 8'h2C);
        do_read(1'b1, 8'h20, 3, rb);
        chk("R2 read 0x20", rb[7:0], 8'h90);
        chk("R5 read inc 0x21", rb[15:8], 8'h2C);
        chk("R2 read 0x22", rb[23:16], 8'h0E);

        // R1: foreign address is not acknowledged and writes nothing
        bus_start();
        wbyte(8'h0E, 1'b0, ack); chk("R1 foreign nack", {7'd0, ack}, 8'd0);
        wbyte(8'h20, 1'b0, ack);
        wbyte(8'h55, 1'b0, ack);
        bus_stop();
        wt(40);
        chk("R1 foreign no write", c0, m0);

        // R3: single write
        do_write(8'h20, 8'hA5, 8'h00, 1, 1'b0);
        chk("R3 ctrl0 written", c0, 8'hA5);

        // R4: pointer kept after STOP, NACK does not advance it
        do_read(1'b1, 8'h21, 1, rb);
        chk("R6 read 0x21", rb[7:0], m1);
        do_read(1'b0, 8'h00, 1, rb);
        chk("R4 reread kept ptr", rb[7:0], m1);
        do_read(1'b0, 8'h00, 1, rb);
        chk("R4 reread again", rb[7:0], m1);

        // R7: read-only and unmapped writes discarded
        stat_i = 8'h3C;
        do_write(8'h22, 8'h77, 8'h00, 1, 1'b0);
        do_read(1'b1, 8'h22, 1, rb);
        chk("R7 status read-only", rb[7:0], 8'h3C);
        do_write(8'h25, 8'h66, 8'h00, 1, 1'b0);
        do_read(1'b1, 8'h25, 1, rb);
        chk("R7 unmapped reads zero", rb[7:0], 8'h00);
        chk("R7 ctrl0 untouched", c0, m0);
        chk("R7 ctrl1 untouched", c1, m1);

        // R9: STOP in the middle of a data byte
        bus_start();
        wbyte(8'h0C, 1'b0, ack);
        wbyte(8'h21, 1'b0, ack);
        clk_bit(1'b1, 1'b0, r); clk_bit(1'b0, 1'b0, r);
        clk_bit(1'b1, 1'b0, r); clk_bit(1'b0, 1'b0, r);
        bus_stop();
        wt(40);
        chk("R9 stop abort ctrl1", c1, m1);

        // R9: repeated START in the middle of a data byte
        bus_start();
        wbyte(8'h0C, 1'b0, ack);
        wbyte(8'h20, 1'b0, ack);
        clk_bit(1'b0, 1'b0, r); clk_bit(1'b1, 1'b0, r); clk_bit(1'b0, 1'b0, r);
        do_read(1'b0, 8'h00, 1, rb);
        chk("R9 start abort read", rb[7:0], m0);
        chk("R9 start abort ctrl0", c0, m0);

        // R8: short SCL pulse inside a data byte
        do_write(8'h21, 8'hC3, 8'h00, 1, 1'b1);
        chk("R8 glitch ignored", c1, 8'hC3);

        // Random rounds
        for (int it = 0; it < 8; it++) begin
            p  = 8'h1F + 8'($urandom_range(0, 4));
            d0 = 8'($urandom);
            d1 = 8'($urandom);
            do_write(p, d0, d1, 2, it[0]);
            chk("R3 rand ctrl0", c0, m0);
            chk("R3 rand ctrl1", c1, m1);
            stat_i = 8'($urandom);
            wt(5);
            q = 8'h1F + 8'($urandom_range(0, 4));
            do_read(1'b1, q, 2, rb);
            chk("R6 rand first", rb[7:0], exp_reg(q));
            chk("R5 rand next", rb[15:8], exp_reg(q + 8'd1));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule